// File: doc/BRIEF.md
# Write-Through Cache Access Controller

This block is a direct-mapped, write-through cache controller shared by instruction and data traffic and indexed by virtual address. A processor issues one request at a time on a valid/ready port. Each request carries two attribute bits: a cacheable bit that applies to reads and an updateable bit that applies to writes. The controller forwards traffic to an external memory port that has a valid/ready request side and a one-cycle response strobe. Cacheable read misses fetch a whole line. Every write goes out to memory, and the cached copy of the word is refreshed only when the write is marked updateable.

A flush strobe invalidates the whole cache in a single cycle. A read accepted in the same cycle as the flush still sees the old contents. A flush that arrives while a line fill is running is held until the fill ends, and the line just fetched is left invalid. A locked read-then-write pair always reads from memory. The lock output stays high from the locked read until the locked write is acknowledged, so that external logic treats the two phases as one indivisible operation.

The default geometry is 64 lines of four 32-bit words, with a 32-bit byte address. Address bits [3:2] select the word, bits [9:4] select the line, and bits [31:10] form the tag.

Top module: `wt_cache_ctrl`

## Requirements
- R1: A read with req_cacheable=0 makes exactly one external read at req_addr and returns its data. No fill starts and no cache state changes.
- R2: Every accepted write makes exactly one external write, with mem_req_write=1, in the cycle after acceptance or later. Its response comes only after the external acknowledgement.
- R3: A write with req_update=1 that hits replaces the cached word. A later cacheable read of that address returns the new data with no external access.
- R4: A write with req_update=0 leaves the cache untouched. A later cacheable read of a previously cached address returns the old cached word with no external access.
- R5: A cacheable, unlocked read miss fetches all four words of the line from external memory, in word order 0,1,2,3. It returns the requested word, and the line hits afterwards.
- R6: A cacheable, unlocked read hit raises rsp_valid in the cycle after acceptance, with the cached word and no external request.
- R7: A flush_wr pulse invalidates every line. A read accepted in the same cycle as the pulse may still hit on the old contents. Reads accepted later miss.
- R8: A flush_wr pulse during a line fill takes effect when the fill ends, and the filled line is left invalid.
- R9: A read with req_lock=1 always reads external memory, even on a hit. mem_lock rises in the cycle after acceptance and falls only when the write response of a following req_lock=1 write arrives.
- R10: The write phase of a locked pair follows the normal write rules: with req_update=1 and a hit, the cached word is updated.
- R11: A hit needs both the valid bit and a tag match. Two addresses with the same line index and different tags evict each other.
- R12: After reset no line is valid, mem_lock=0, rsp_valid=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cacheable | input | 1 | Read may use the cache |
| req_update | input | 1 | Write may update a cached copy |
| req_lock | input | 1 | Request is a phase of a locked read-then-write pair |
| req_addr | input | ADDR_W | Byte address (virtual) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid for reads |
| flush_wr | input | 1 | Flush-register write strobe |
| mem_req_valid | output | 1 | External request valid |
| mem_req_ready | input | 1 | External side accepts the request |
| mem_req_write | output | 1 | External request is a write |
| mem_req_addr | output | ADDR_W | External byte address |
| mem_req_wdata | output | DATA_W | External write data |
| mem_rsp_valid | input | 1 | External response or write acknowledgement |
| mem_rsp_rdata | input | DATA_W | External read data |
| mem_lock | output | 1 | Indivisible-pair indicator |

## Verification
The bench builds the controller with its default geometry: 64 lines, four words per line and 32-bit address and data. It draws addresses from eight line indices and four tags, so random traffic keeps producing hits, conflict evictions, stale lines after non-updating writes and refills. The external side stalls its ready at random, which moves every fill beat and every write acknowledgement to varying cycles. Directed sequences place a flush in the acceptance cycle of a hit and in the middle of a fill, and run locked pairs over cached lines.

// File: rtl/wtc_pkg.sv
// Package: shared types for the write-through cache controller.
// Assumes: nothing beyond IEEE 1800-2017.
package wtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } wtc_state_e;

endpackage

// File: rtl/wtc_tag_store.sv
// Tag and valid storage with a combinational lookup port.
// Installing a tag clears that line's valid bit. Setting a line valid marks it
// usable. A flush clears all valid bits in one cycle and wins over both.
// Assumes: one install and one set per cycle at most.
module wtc_tag_store #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             flush_all
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] line_ok;
    logic [TAG_W-1:0] tag_mem [LINES];

    // Hit: line valid and stored tag equal to the lookup tag.
    always_comb lk_hit = line_ok[lk_idx] && (tag_mem[lk_idx] == lk_tag);

    // Valid bits: flush, install-clear and fill-complete set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_ok <= '0;
        end else if (flush_all) begin
            line_ok <= '0;
        end else begin
            if (wr_en)  line_ok[wr_idx]  <= 1'b0;
            if (set_en) line_ok[set_idx] <= 1'b1;
        end
    end

    // Tag array: written when a fill starts, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx] <= wr_tag;
    end
endmodule

// File: rtl/wtc_data_store.sv
// Word-addressed data array with one combinational read port and one write port.
// Assumes: the address is {line index, word within line}.
module wtc_data_store #(
    parameter int AW     = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] words [DEPTH];

    // Read: asynchronous lookup of the addressed word.
    always_comb rd_data = words[rd_addr];

    // Write: one word per cycle from a fill beat or an updating write.
    always_ff @(posedge clk) begin
        if (we) words[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/wtc_seq.sv
// Access sequencer: accepts one processor request at a time and decides
// hit, fill, bypass or write-through. It drives the external port with at
// most one outstanding request, steers the store updates and owns the lock
// and the deferred flush.
// Assumes: words per line is a power of two; the external side answers each
// accepted request with exactly one mem_rsp_valid pulse.
module wtc_seq
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int OFS_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic                    req_cacheable,
    input  logic                    req_update,
    input  logic                    req_lock,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    input  logic                    flush_wr,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic                    mem_req_write,
    output logic [ADDR_W-1:0]       mem_req_addr,
    output logic [DATA_W-1:0]       mem_req_wdata,
    input  logic                    mem_rsp_valid,
    input  logic [DATA_W-1:0]       mem_rsp_rdata,
    output logic                    mem_lock,
    input  logic                    lk_hit,
    input  logic [DATA_W-1:0]       rd_data,
    output logic                    tag_wr,
    output logic [IDX_W-1:0]        tag_wr_idx,
    output logic [ADDR_W-IDX_W-OFS_W-$clog2(DATA_W/8)-1:0] tag_wr_tag,
    output logic                    set_valid,
    output logic [IDX_W-1:0]        set_idx,
    output logic                    flush_all,
    output logic                    dwe,
    output logic [IDX_W+OFS_W-1:0]  dwaddr,
    output logic [DATA_W-1:0]       dwdata
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int LN_LO  = BYTE_W + OFS_W;
    localparam int IDX_HI = LN_LO + IDX_W - 1;

    wtc_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [OFS_W-1:0]  beat;
    logic              issued;
    logic              lock_q;
    logic              lk_q;
    logic              flush_pend;

    logic accept, rd_plain, hit_rd, fill_start, wr_upd, beat_done, fill_end;

    // Request classification in the acceptance cycle.
    always_comb begin
        accept     = req_valid && (state == ST_IDLE);
        rd_plain   = accept && !req_write && req_cacheable && !req_lock;
        hit_rd     = rd_plain && lk_hit;
        fill_start = rd_plain && !lk_hit;
        wr_upd     = accept && req_write && req_update && lk_hit;
        beat_done  = (state == ST_FILL) && mem_rsp_valid;
        fill_end   = beat_done && (beat == {OFS_W{1'b1}});
    end

    // Store control: tag install, line set, flush and the data write port.
    always_comb begin
        tag_wr     = fill_start;
        tag_wr_idx = req_addr[IDX_HI:LN_LO];
        tag_wr_tag = req_addr[ADDR_W-1:IDX_HI+1];
        set_valid  = fill_end && !flush_pend && !flush_wr;
        set_idx    = addr_q[IDX_HI:LN_LO];
        flush_all  = (flush_wr && (state != ST_FILL)) ||
                     (fill_end && (flush_pend || flush_wr));
        dwe        = wr_upd || beat_done;
        if (state == ST_FILL) begin
            dwaddr = {addr_q[IDX_HI:LN_LO], beat};
            dwdata = mem_rsp_rdata;
        end else begin
            dwaddr = req_addr[IDX_HI:BYTE_W];
            dwdata = req_wdata;
        end
    end

    // External port and processor-side outputs.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state != ST_IDLE) && !issued;
        mem_req_write = (state == ST_WR);
        mem_req_wdata = wdata_q;
        mem_lock      = lock_q;
        if (state == ST_FILL)
            mem_req_addr = {addr_q[ADDR_W-1:LN_LO], beat, {BYTE_W{1'b0}}};
        else
            mem_req_addr = addr_q;
    end

    // Sequencing: request capture, fill beats, responses, lock and deferred flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            addr_q     <= '0;
            wdata_q    <= '0;
            beat       <= '0;
            issued     <= 1'b0;
            lock_q     <= 1'b0;
            lk_q       <= 1'b0;
            flush_pend <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) issued <= 1'b1;
            if (mem_rsp_valid)                  issued <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        lk_q    <= req_lock;
                        beat    <= '0;
                        if (!req_write && req_lock) lock_q <= 1'b1;
                        if (hit_rd) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= rd_data;
                        end else if (fill_start) begin
                            state <= ST_FILL;
                        end else if (req_write) begin
                            state <= ST_WR;
                        end else begin
                            state <= ST_RD;
                        end
                    end
                end
                ST_FILL: begin
                    if (flush_wr) flush_pend <= 1'b1;
                    if (beat_done) begin
                        if (beat == addr_q[LN_LO-1:BYTE_W]) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= mem_rsp_rdata;
                        end
                        beat <= beat + 1'b1;
                        if (fill_end) begin
                            state      <= ST_IDLE;
                            flush_pend <= 1'b0;
                        end
                    end
                end
                ST_RD: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= mem_rsp_rdata;
                        state     <= ST_IDLE;
                    end
                end
                default: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        state     <= ST_IDLE;
                        if (lk_q) lock_q <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/wt_cache_ctrl.sv
// Top: direct-mapped write-through cache controller, virtually indexed.
// Joins the sequencer to the tag/valid store and the data array. Lookups
// use the live request address so a hit answers in the next cycle.
// Assumes: LINES and WORDS_PER_LINE are powers of two; byte addresses.
module wt_cache_ctrl #(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int LINES          = 64,
    parameter int WORDS_PER_LINE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_cacheable,
    input  logic              req_update,
    input  logic              req_lock,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              flush_wr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              mem_lock
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int OFS_W  = $clog2(WORDS_PER_LINE);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int LN_LO  = BYTE_W + OFS_W;
    localparam int TAG_W  = ADDR_W - IDX_W - LN_LO;
    localparam int DA_W   = IDX_W + OFS_W;

    logic              lk_hit;
    logic [DATA_W-1:0] rd_data;
    logic              tag_wr, set_valid, flush_all, dwe;
    logic [IDX_W-1:0]  tag_wr_idx, set_idx;
    logic [TAG_W-1:0]  tag_wr_tag;
    logic [DA_W-1:0]   dwaddr;
    logic [DATA_W-1:0] dwdata;

    wtc_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFS_W(OFS_W)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_cacheable(req_cacheable), .req_update(req_update),
        .req_lock(req_lock), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .flush_wr(flush_wr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .mem_lock(mem_lock),
        .lk_hit(lk_hit), .rd_data(rd_data),
        .tag_wr(tag_wr), .tag_wr_idx(tag_wr_idx), .tag_wr_tag(tag_wr_tag),
        .set_valid(set_valid), .set_idx(set_idx), .flush_all(flush_all),
        .dwe(dwe), .dwaddr(dwaddr), .dwdata(dwdata)
    );

    wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(req_addr[LN_LO+IDX_W-1:LN_LO]),
        .lk_tag(req_addr[ADDR_W-1:LN_LO+IDX_W]),
        .lk_hit(lk_hit),
        .wr_en(tag_wr), .wr_idx(tag_wr_idx), .wr_tag(tag_wr_tag),
        .set_en(set_valid), .set_idx(set_idx), .flush_all(flush_all)
    );

    wtc_data_store #(.AW(DA_W), .DATA_W(DATA_W)) i_data (
        .clk(clk),
        .rd_addr(req_addr[LN_LO+IDX_W-1:BYTE_W]), .rd_data(rd_data),
        .we(dwe), .wr_addr(dwaddr), .wr_data(dwdata)
    );
endmodule

// File: rtl/wtc_checker.sv
// Protocol checker for wt_cache_ctrl, attached with bind below.
// Assumes: word offset bits sit directly above the two byte bits.
module wtc_checker #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              req_cacheable,
    input logic              req_lock,
    input logic [ADDR_W-1:0] req_addr,
    input logic              lk_hit,
    input logic              rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              mem_lock
);
    logic acc;
    always_comb acc = req_valid && req_ready;

    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write) |=> (mem_req_valid && mem_req_write)); // R2
    AST_BYPASS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && !req_cacheable) |=>
        (mem_req_valid && !mem_req_write && mem_req_addr == $past(req_addr))); // R1
    AST_FILL_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_cacheable && !req_lock && !lk_hit) |=>
        (mem_req_valid && !mem_req_write && mem_req_addr[OFS_W+1:2] == '0)); // R5
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_cacheable && !req_lock && lk_hit) |=>
        (rsp_valid && !mem_req_valid)); // R6
    AST_LOCKED_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_lock) |=>
        (mem_lock && mem_req_valid && !mem_req_write)); // R9
    AST_LOCK_ENDS_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> $past(mem_rsp_valid)); // R9
endmodule

bind wt_cache_ctrl wtc_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_wtc_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cacheable(req_cacheable), .req_lock(req_lock),
    .req_addr(req_addr), .lk_hit(lk_hit), .rsp_valid(rsp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_lock(mem_lock)
);

// File: tb/test_wt_cache_ctrl.sv
// Bench: random traffic from a fixed seed plus directed corner cases. A
// reference cache model and a memory model in the bench give expected read
// data and external access counts.
module test_wt_cache_ctrl;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_cacheable = 1'b0;
    logic          req_update = 1'b0, req_lock = 1'b0, flush_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, mem_req_valid, mem_req_write, mem_lock;
    logic [DW-1:0] rsp_rdata, mem_req_wdata;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b1;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_rdata = '0;

    int checks = 0;
    int errors = 0;
    int ext_cnt = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    wt_cache_ctrl i_wt_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_cacheable(req_cacheable),
        .req_update(req_update), .req_lock(req_lock), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .flush_wr(flush_wr), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .mem_lock(mem_lock)
    );

    // External memory model.
    logic [DW-1:0] mem [logic [AW-1:0]];

    function automatic logic [DW-1:0] rd_mem(logic [AW-1:0] a);
        logic [AW-1:0] w = {a[AW-1:2], 2'b00};
        if (mem.exists(w)) return mem[w];
        return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            ext_cnt++;
            mem_rsp_valid <= 1'b1;
            if (mem_req_write) mem[{mem_req_addr[AW-1:2], 2'b00}] = mem_req_wdata;
            else mem_rsp_rdata <= rd_mem(mem_req_addr);
        end
    end

    always @(negedge clk) mem_req_ready <= ($urandom % 4) != 0;

    // Reference cache model.
    logic          m_ok  [NL];
    logic [21:0]   m_tag [NL];
    logic [DW-1:0] m_dat [NL][4];

    function automatic logic m_hit(logic [AW-1:0] a);
        return m_ok[a[9:4]] && (m_tag[a[9:4]] == a[31:10]);
    endfunction

    task automatic check(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic m_flush();
        for (int i = 0; i < NL; i++) m_ok[i] = 1'b0;
    endtask

    // One request. fl: -1 none, 0 flush in the acceptance cycle, >0 flush
    // that many cycles later. Returns read data and external access count.
    task automatic run_op(input logic w, c, u, lk, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int fl, input string tg,
                          output logic [DW-1:0] rd, output int ext);
        logic hit = m_hit(a);
        logic [DW-1:0] exp_d;
        int exp_e;
        int e0, n;
        logic got = 1'b0;
        string r = tg;
        logic [DW-1:0] line [4];
        for (int k = 0; k < 4; k++) line[k] = rd_mem({a[31:4], k[1:0], 2'b00});
        if (w) begin exp_e = 1; exp_d = '0; if (r == "") r = u ? "R3" : "R4"; end
        else if (!c) begin exp_e = 1; exp_d = rd_mem(a); if (r == "") r = "R1"; end
        else if (lk) begin exp_e = 1; exp_d = rd_mem(a); if (r == "") r = "R9"; end
        else if (hit) begin exp_e = 0; exp_d = m_dat[a[9:4]][a[3:2]]; if (r == "") r = "R6"; end
        else begin exp_e = 4; exp_d = rd_mem(a); if (r == "") r = "R5"; end
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_cacheable = c; req_update = u;
        req_lock = lk; req_addr = a; req_wdata = d;
        if (fl == 0) flush_wr = 1'b1;
        while (!req_ready) @(negedge clk);
        e0 = ext_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        forever begin
            flush_wr = 1'b0;
            if (rsp_valid) begin got = 1'b1; rd = rsp_rdata; end
            if (got && req_ready) break;
            n++;
            if (fl > 0 && n == fl) flush_wr = 1'b1;
            @(negedge clk);
        end
        ext = ext_cnt - e0;
        check({r, " external count"}, ext, exp_e);
        if (!w) check({r, " read data"}, rd, exp_d);
        if (fl == 0) m_flush();
        if (w && u && hit) m_dat[a[9:4]][a[3:2]] = d;
        if (!w && c && !lk && !hit) begin
            m_tag[a[9:4]] = a[31:10];
            for (int k = 0; k < 4; k++) m_dat[a[9:4]][k] = line[k];
            m_ok[a[9:4]] = 1'b1;
        end
        if (fl > 0) m_flush();
    endtask

    task automatic do_flush();
        @(negedge clk); flush_wr = 1'b1;
        @(negedge clk); flush_wr = 1'b0;
        m_flush();
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        int ext;
        logic [AW-1:0] a;
        void'($urandom(32'd1234));
        m_flush();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 req_ready", req_ready, 1);
        check("R12 mem_lock", mem_lock, 0);
        check("R12 rsp_valid", rsp_valid, 0);
        run_op(0, 1, 0, 0, 32'h0000_0048, 0, -1, "R12", rd, ext);

        // R5 fill of word 2, then R6 hits on the same line
        run_op(0, 1, 0, 0, 32'h0000_1028, 0, -1, "R5", rd, ext);
        run_op(0, 1, 0, 0, 32'h0000_1020, 0, -1, "R6", rd, ext);
        run_op(0, 1, 0, 0, 32'h0000_102C, 0, -1, "R6", rd, ext);
        // R1 bypass: uncached read of a missing line leaves it missing
        run_op(0, 0, 0, 0, 32'h0000_2050, 0, -1, "R1", rd, ext);
        run_op(0, 1, 0, 0, 32'h0000_2050, 0, -1, "R1 no fill", rd, ext);
        // R3 and R4 on the cached line 2
        run_op(1, 0, 1, 0, 32'h0000_1024, 32'hCAFE_0001, -1, "R3", rd, ext);
        run_op(0, 1, 0, 0, 32'h0000_1024, 0, -1, "R3 readback", rd, ext);
        run_op(1, 0, 0, 0, 32'h0000_1020, 32'hBEEF_0002, -1, "R4", rd, ext);
        run_op(0, 1, 0, 0, 32'h0000_1020, 0, -1, "R4 stale", rd, ext);
        run_op(0, 0, 0, 0, 32'h0000_1020, 0, -1, "R2 memory written", rd, ext);
        // R11 conflict on one index
        run_op(0, 1, 0, 0, 32'h0000_0450, 0, -1, "R11", rd, ext);
        run_op(0, 1, 0, 0, 32'h0000_0850, 0, -1, "R11", rd, ext);
        run_op(0, 1, 0, 0, 32'h0000_0450, 0, -1, "R11 evicted", rd, ext);
        // R7 flush in the acceptance cycle of a hit, then miss
        run_op(0, 1, 0, 0, 32'h0000_0450, 0, 0, "R7 same cycle", rd, ext);
        run_op(0, 1, 0, 0, 32'h0000_0450, 0, -1, "R7 after", rd, ext);
        do_flush();
        run_op(0, 1, 0, 0, 32'h0000_0450, 0, -1, "R7 idle flush", rd, ext);
        // R8 flush during a fill
        run_op(0, 1, 0, 0, 32'h0000_3070, 0, 3, "R8 fill", rd, ext);
        run_op(0, 1, 0, 0, 32'h0000_3070, 0, -1, "R8 line invalid", rd, ext);
        // R9 and R10 locked pair over a cached line
        run_op(0, 1, 0, 0, 32'h0000_00A4, 0, -1, "R9 prefill", rd, ext);
        run_op(0, 1, 0, 1, 32'h0000_00A4, 0, -1, "R9", rd, ext);
        check("R9 lock held between phases", mem_lock, 1);
        run_op(1, 0, 1, 1, 32'h0000_00A4, 32'h1234_5678, -1, "R10", rd, ext);
        check("R9 lock released", mem_lock, 0);
        run_op(0, 1, 0, 0, 32'h0000_00A4, 0, -1, "R10 readback", rd, ext);

        // Random phase
        for (int i = 0; i < 600; i++) begin
            a = (($urandom % 4) << 10) | (($urandom % 8) << 4) | (($urandom % 4) << 2);
            if ($urandom % 20 == 0) begin
                run_op(0, 1, 0, 1, a, 0, -1, "R9", rd, ext);
                check("R9 lock held", mem_lock, 1);
                run_op(1, 0, $urandom % 2, 1, a, $urandom, -1, "R10", rd, ext);
                check("R9 lock released", mem_lock, 0);
            end else if ($urandom % 40 == 0) begin
                do_flush();
            end else begin
                run_op($urandom % 3 == 0, $urandom % 4 != 0, $urandom % 2, 0,
                       a, $urandom, -1, "", rd, ext);
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule